// File: doc/BRIEF.md
# SPI Opcode Decoder with Configuration Pins and NAND Byte Bridge

This block is a serial-peripheral slave placed inside a small programmable logic device next to a host processor. The host selects the device, sends a one-byte opcode in SPI mode 0 (clock idles low, both sides sample on the rising edge, most significant bit first), and then sends or receives the bytes that the opcode calls for. Opcodes load an eight-bit register whose bits drive board pins (four active-low LEDs and an active-low NAND chip enable), turn a fifth LED on or off, or move bytes between the serial link and a byte-wide NAND data port.

The serial pins are oversampled in the system clock domain. Each NAND-side event is a single-cycle pulse in that domain. Neither stream can apply back-pressure, because the host owns the serial clock and cannot be stalled. `nand_wr_valid` is a valid strobe without a ready: the NAND side must take `nand_wr_data` in that same cycle. `nand_rd_req` asks for one byte, and the NAND side must hold that byte on `nand_rd_data` during the next cycle. Each opcode frames its bytes in its own way. A write stream ends with one idle byte that is not data. A plain read is preceded by one idle byte. A fast read is preceded by a three-byte address and one dummy byte.

Top module: `spi_cmd_decoder`

## Requirements
- R1: After reset `cfg_pins` is 0x1F (bits 3:0 drive the four LEDs off, bit 4 deselects the NAND), `led5_n` is 1, and neither `nand_wr_valid` nor `nand_rd_req` is pulsed.
- R2: Opcode 0x09 followed by one byte loads that byte into `cfg_pins`. Any further bytes in the same selection leave `cfg_pins` unchanged.
- R3: Opcode 0x0C drives `led5_n` low and opcode 0x0D drives it high. Bytes that follow either opcode are ignored.
- R4: After opcode 0x08, every received byte except the last one of the selection appears on `nand_wr_data` with a one-cycle `nand_wr_valid`. A byte is issued only once the byte after it has fully arrived, so the closing idle byte is never issued.
- R5: After opcode 0x0A and one idle byte, each further byte period shifts out on MISO, MSB first, one byte taken from `nand_rd_data`. The first such byte is fetched at the end of the idle byte.
- R6: Opcode 0x0B is followed by a 24-bit address, most significant byte first, which is presented on `nand_addr`. One dummy byte follows, then read bytes as in R5. `nand_addr` increases by one after each read request.
- R7: Each read fetch is a single-cycle `nand_rd_req`, and the byte is sampled from `nand_rd_data` in the following cycle. A read of N data bytes produces N+1 requests, because the last one is a prefetch.
- R8: Raising `spi_cs_n` abandons the transaction. A partly received byte and a held write byte are discarded, and the next selection starts with an opcode.
- R9: An opcode outside {0x08, 0x09, 0x0A, 0x0B, 0x0C, 0x0D} causes every byte up to the next deselection to be ignored.
- R10: `spi_miso_oe` equals the inverse of `spi_cs_n`. `spi_miso` is 0 whenever it is not driven, and also during opcode, address, dummy and idle bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from host, idle low |
| spi_mosi | input | 1 | Serial data from host |
| spi_cs_n | input | 1 | Active-low select |
| spi_miso | output | 1 | Serial data to host |
| spi_miso_oe | output | 1 | Drive enable for the MISO pad |
| cfg_pins | output | 8 | Configuration register driving board pins |
| led5_n | output | 1 | Separate active-low LED |
| nand_wr_valid | output | 1 | One-cycle strobe: write byte valid |
| nand_wr_data | output | 8 | Byte to write to NAND |
| nand_rd_req | output | 1 | One-cycle request for a NAND byte |
| nand_rd_data | input | 8 | NAND byte, valid the cycle after a request |
| nand_addr | output | 24 | Fast-read address, advancing per request |

## Verification
If the decoder's state is wrong, it shows up on the pins within one byte period. A lost opcode state turns a configuration load into ignored bytes, or a write into spurious read requests. An off-by-one in the held write byte issues the idle byte as data or drops the first byte. A bit counter that is off shifts every MISO byte by one bit from the first data byte on. A missing abort clear shows up on the very next selection as a misread opcode. The reference model tracks every strobe and every MISO byte in the cycle it occurs.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] OP_NAND_WR = 8'h08;
  localparam logic [BYTE_W-1:0] OP_CFG_WR  = 8'h09;
  localparam logic [BYTE_W-1:0] OP_NAND_RD = 8'h0A;
  localparam logic [BYTE_W-1:0] OP_FAST_RD = 8'h0B;
  localparam logic [BYTE_W-1:0] OP_LED_ON  = 8'h0C;
  localparam logic [BYTE_W-1:0] OP_LED_OFF = 8'h0D;

  typedef enum logic [2:0] {
    ST_OPCODE,
    ST_CFG,
    ST_WRITE,
    ST_RD_IDLE,
    ST_ADDR,
    ST_DUMMY,
    ST_RD_DATA,
    ST_IGNORE
  } dec_state_t;
endpackage

// File: rtl/spi_cmd_sync.sv
module spi_cmd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic mosi_i,
  input  logic cs_n_i,
  output logic cs_act,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic mosi_s
);
  localparam int NSIG = 3;
  localparam logic [NSIG-1:0] RST_V = 3'b100;

  logic [NSIG-1:0] raw;
  logic [NSIG-1:0] synced;
  logic            sclk_d;

  assign raw = {cs_n_i, mosi_i, sclk_i};

  for (genvar g = 0; g < NSIG; g++) begin : g_sync
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_V[g]}};
      else        chain <= {chain[STAGES-2:0], raw[g]};
    end
    assign synced[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d <= 1'b0;
    else        sclk_d <= synced[0];
  end

  assign cs_act    = ~synced[2];
  assign mosi_s    = synced[1];
  assign sclk_rise = cs_act & synced[0] & ~sclk_d;
  assign sclk_fall = cs_act & ~synced[0] & sclk_d;
endmodule

// File: rtl/spi_cmd_shift.sv
module spi_cmd_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_act,
  input  logic         sclk_rise,
  input  logic         sclk_fall,
  input  logic         mosi_s,
  input  logic         tx_load,
  input  logic [W-1:0] tx_byte,
  output logic         byte_done,
  output logic [W-1:0] rx_byte,
  output logic         tx_bit
);
  localparam int CNT_W = $clog2(W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(W - 1);

  logic [CNT_W-1:0] bit_cnt;
  logic [W-1:0]     rx_sh;
  logic [W-1:0]     tx_sh;
  logic [W-1:0]     rx_next;

  assign rx_next = {rx_sh[W-2:0], mosi_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt   <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      rx_byte   <= '0;
      byte_done <= 1'b0;
    end else if (!cs_act) begin
      bit_cnt   <= '0;
      tx_sh     <= '0;
      byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (sclk_rise) begin
        rx_sh   <= rx_next;
        bit_cnt <= (bit_cnt == CNT_LAST) ? '0 : bit_cnt + 1'b1;
        if (bit_cnt == CNT_LAST) begin
          byte_done <= 1'b1;
          rx_byte   <= rx_next;
          tx_sh     <= '0;
        end
      end else if (sclk_fall && bit_cnt != '0) begin
        tx_sh <= {tx_sh[W-2:0], 1'b0};
      end else if (tx_load) begin
        tx_sh <= tx_byte;
      end
    end
  end

  assign tx_bit = tx_sh[W-1];
endmodule

// File: rtl/spi_cmd_ctrl.sv
module spi_cmd_ctrl
  import spi_cmd_pkg::*;
#(
  parameter int          W          = 8,
  parameter int          ADDR_BYTES = 3,
  parameter logic [W-1:0] CFG_RESET = 8'h1F
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cs_act,
  input  logic                    byte_done,
  input  logic [W-1:0]            rx_byte,
  input  logic [W-1:0]            nand_rd_data,
  output logic [W-1:0]            cfg_q,
  output logic                    led5_n,
  output logic                    wr_valid,
  output logic [W-1:0]            wr_data,
  output logic                    rd_req,
  output logic [W*ADDR_BYTES-1:0] rd_addr,
  output logic                    tx_load,
  output logic [W-1:0]            tx_byte
);
  localparam int AW    = W * ADDR_BYTES;
  localparam int IDX_W = $clog2(ADDR_BYTES);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(ADDR_BYTES - 1);

  dec_state_t       st;
  logic [W-1:0]     held;
  logic             held_v;
  logic             fast;
  logic [IDX_W-1:0] idx;
  logic             rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_OPCODE;
      held     <= '0;
      held_v   <= 1'b0;
      fast     <= 1'b0;
      idx      <= '0;
      rd_q     <= 1'b0;
      cfg_q    <= CFG_RESET;
      led5_n   <= 1'b1;
      wr_valid <= 1'b0;
      wr_data  <= '0;
      rd_req   <= 1'b0;
      rd_addr  <= '0;
    end else begin
      wr_valid <= 1'b0;
      rd_req   <= 1'b0;
      rd_q     <= rd_req;
      if (rd_req && fast) rd_addr <= rd_addr + 1'b1;
      if (!cs_act) begin
        st     <= ST_OPCODE;
        held_v <= 1'b0;
        fast   <= 1'b0;
        rd_q   <= 1'b0;
      end else if (byte_done) begin
        unique case (st)
          ST_OPCODE: begin
            unique case (rx_byte)
              OP_CFG_WR:  st <= ST_CFG;
              OP_LED_ON:  begin led5_n <= 1'b0; st <= ST_IGNORE; end
              OP_LED_OFF: begin led5_n <= 1'b1; st <= ST_IGNORE; end
              OP_NAND_WR: begin held_v <= 1'b0; st <= ST_WRITE; end
              OP_NAND_RD: begin fast <= 1'b0; st <= ST_RD_IDLE; end
              OP_FAST_RD: begin fast <= 1'b1; idx <= '0; st <= ST_ADDR; end
              default:    st <= ST_IGNORE;
            endcase
          end
          ST_CFG: begin
            cfg_q <= rx_byte;
            st    <= ST_IGNORE;
          end
          ST_WRITE: begin
            if (held_v) begin
              wr_valid <= 1'b1;
              wr_data  <= held;
            end
            held   <= rx_byte;
            held_v <= 1'b1;
          end
          ST_RD_IDLE: begin
            rd_req <= 1'b1;
            st     <= ST_RD_DATA;
          end
          ST_ADDR: begin
            rd_addr <= {rd_addr[AW-W-1:0], rx_byte};
            idx     <= idx + 1'b1;
            if (idx == IDX_LAST) st <= ST_DUMMY;
          end
          ST_DUMMY: begin
            rd_req <= 1'b1;
            st     <= ST_RD_DATA;
          end
          ST_RD_DATA: rd_req <= 1'b1;
          default:    st <= ST_IGNORE;
        endcase
      end
    end
  end

  assign tx_load = rd_q;
  assign tx_byte = nand_rd_data;
endmodule

// File: rtl/spi_cmd_decoder.sv
module spi_cmd_decoder #(
  parameter int         DATA_W      = 8,
  parameter int         ADDR_BYTES  = 3,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] CFG_RESET   = 8'h1F
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         spi_sclk,
  input  logic                         spi_mosi,
  input  logic                         spi_cs_n,
  output logic                         spi_miso,
  output logic                         spi_miso_oe,
  output logic [DATA_W-1:0]            cfg_pins,
  output logic                         led5_n,
  output logic                         nand_wr_valid,
  output logic [DATA_W-1:0]            nand_wr_data,
  output logic                         nand_rd_req,
  input  logic [DATA_W-1:0]            nand_rd_data,
  output logic [DATA_W*ADDR_BYTES-1:0] nand_addr
);
  logic              cs_act;
  logic              sclk_rise;
  logic              sclk_fall;
  logic              mosi_s;
  logic              byte_done;
  logic [DATA_W-1:0] rx_byte;
  logic              tx_load;
  logic [DATA_W-1:0] tx_byte;
  logic              tx_bit;

  spi_cmd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_i    (spi_sclk),
    .mosi_i    (spi_mosi),
    .cs_n_i    (spi_cs_n),
    .cs_act    (cs_act),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .mosi_s    (mosi_s)
  );

  spi_cmd_shift #(.W(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_act    (cs_act),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .mosi_s    (mosi_s),
    .tx_load   (tx_load),
    .tx_byte   (tx_byte),
    .byte_done (byte_done),
    .rx_byte   (rx_byte),
    .tx_bit    (tx_bit)
  );

  spi_cmd_ctrl #(
    .W          (DATA_W),
    .ADDR_BYTES (ADDR_BYTES),
    .CFG_RESET  (CFG_RESET)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_act       (cs_act),
    .byte_done    (byte_done),
    .rx_byte      (rx_byte),
    .nand_rd_data (nand_rd_data),
    .cfg_q        (cfg_pins),
    .led5_n       (led5_n),
    .wr_valid     (nand_wr_valid),
    .wr_data      (nand_wr_data),
    .rd_req       (nand_rd_req),
    .rd_addr      (nand_addr),
    .tx_load      (tx_load),
    .tx_byte      (tx_byte)
  );

  assign spi_miso_oe = ~spi_cs_n;
  assign spi_miso    = spi_miso_oe & tx_bit;
endmodule

// File: rtl/spi_cmd_checker.sv
module spi_cmd_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_act,
  input logic              spi_miso,
  input logic [DATA_W-1:0] cfg_pins,
  input logic              led5_n,
  input logic              nand_wr_valid,
  input logic              nand_rd_req
);
  a_r4_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
    nand_wr_valid |=> !nand_wr_valid);

  a_r7_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
    nand_rd_req |=> !nand_rd_req);

  a_r8_no_wr_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_act && !$past(cs_act)) |-> !nand_wr_valid);

  a_r8_no_rd_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_act && !$past(cs_act)) |-> !nand_rd_req);

  a_r10_miso_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_act && !$past(cs_act)) |-> !spi_miso);

  a_r2_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_act && !$past(cs_act)) |-> $stable(cfg_pins));

  a_r3_led_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_act && !$past(cs_act)) |-> $stable(led5_n));
endmodule

bind spi_cmd_decoder spi_cmd_checker #(.DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cs_act        (cs_act),
  .spi_miso      (spi_miso),
  .cfg_pins      (cfg_pins),
  .led5_n        (led5_n),
  .nand_wr_valid (nand_wr_valid),
  .nand_rd_req   (nand_rd_req)
);

// File: tb/sim_spi_cmd_decoder.sv
module sim_spi_cmd_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        spi_sclk = 1'b0;
  logic        spi_mosi = 1'b0;
  logic        spi_cs_n = 1'b1;
  logic        spi_miso;
  logic        spi_miso_oe;
  logic [7:0]  cfg_pins;
  logic        led5_n;
  logic        nand_wr_valid;
  logic [7:0]  nand_wr_data;
  logic        nand_rd_req;
  logic [7:0]  nand_rd_data = 8'h00;
  logic [23:0] nand_addr;

  int tests = 0;
  int fails = 0;
  int wr_total = 0;
  int rd_total = 0;
  bit quiet = 1'b1;
  bit done = 1'b0;
  logic [7:0]  exp_cfg = 8'h1F;
  logic        exp_led = 1'b1;
  logic [7:0]  exp_wr[$];
  logic [7:0]  rd_vals[$];
  logic [23:0] addr_log[$];

  always #5 clk = ~clk;

  spi_cmd_decoder u0 (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_cs_n(spi_cs_n), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .cfg_pins(cfg_pins), .led5_n(led5_n), .nand_wr_valid(nand_wr_valid),
    .nand_wr_data(nand_wr_data), .nand_rd_req(nand_rd_req),
    .nand_rd_data(nand_rd_data), .nand_addr(nand_addr)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] rsp(input int n, input logic [23:0] a);
    return 8'(n * 29 + 91) ^ a[7:0] ^ a[15:8];
  endfunction

  // reference model, compared on every clock
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(spi_miso_oe === !spi_cs_n, "R10 oe", spi_miso_oe, !spi_cs_n);
      if (spi_cs_n) check(spi_miso === 1'b0, "R10 idle miso", spi_miso, 0);
      if (quiet) begin
        check(cfg_pins === exp_cfg, "R2 cfg", cfg_pins, exp_cfg);
        check(led5_n === exp_led, "R3 led5", led5_n, exp_led);
      end
      if (nand_wr_valid) begin
        wr_total++;
        if (exp_wr.size() == 0) check(1'b0, "R4 unexpected write", nand_wr_data, 0);
        else begin
          logic [7:0] e;
          e = exp_wr.pop_front();
          check(nand_wr_data === e, "R4 write data", nand_wr_data, e);
        end
      end
      if (nand_rd_req) begin
        logic [7:0] v;
        v = rsp(rd_total, nand_addr);
        addr_log.push_back(nand_addr);
        rd_vals.push_back(v);
        nand_rd_data = v;
        rd_total++;
      end
    end
  end

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx,
                          input int nbits = 8);
    rx = 8'h00;
    for (int i = 7; i > 7 - nbits; i--) begin
      spi_mosi = tx[i];
      repeat (6) @(negedge clk);
      rx[i] = spi_miso;
      spi_sclk = 1'b1;
      repeat (6) @(negedge clk);
      spi_sclk = 1'b0;
    end
  endtask

  task automatic cs_begin();
    quiet = 1'b0;
    @(negedge clk);
    spi_cs_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic cs_end();
    repeat (6) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic settle();
    quiet = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    logic [7:0] r;
    int base, wbase;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(cfg_pins === 8'h1F, "R1 cfg reset", cfg_pins, 8'h1F);
    check(led5_n === 1'b1, "R1 led5 reset", led5_n, 1);
    check(spi_miso_oe === 1'b0, "R1 oe reset", spi_miso_oe, 0);
    check(wr_total == 0 && rd_total == 0, "R1 no strobes", wr_total + rd_total, 0);

    // R2 config load, MISO silent (R10)
    cs_begin();
    spi_byte(8'h09, r); check(r == 0, "R10 opcode miso", r, 0);
    spi_byte(8'hA6, r); check(r == 0, "R10 cfg byte miso", r, 0);
    cs_end(); exp_cfg = 8'hA6; settle();
    check(cfg_pins === 8'hA6, "R2 cfg load", cfg_pins, 8'hA6);

    // R2 extra bytes ignored
    cs_begin();
    spi_byte(8'h09, r); spi_byte(8'h5A, r); spi_byte(8'hFF, r); spi_byte(8'h00, r);
    cs_end(); exp_cfg = 8'h5A; settle();
    check(cfg_pins === 8'h5A, "R2 extra ignored", cfg_pins, 8'h5A);

    // R3 LED on with trailing ignored bytes, then off
    cs_begin(); spi_byte(8'h0C, r); spi_byte(8'h09, r); spi_byte(8'h00, r);
    cs_end(); exp_led = 1'b0; settle();
    check(led5_n === 1'b0 && cfg_pins === 8'h5A, "R3 led on", {cfg_pins, led5_n}, {8'h5A, 1'b0});
    cs_begin(); spi_byte(8'h0D, r); cs_end(); exp_led = 1'b1; settle();
    check(led5_n === 1'b1, "R3 led off", led5_n, 1);

    // R4 write stream with trailing idle byte
    wbase = wr_total;
    cs_begin(); spi_byte(8'h08, r);
    exp_wr.push_back(8'h11); exp_wr.push_back(8'h22); exp_wr.push_back(8'hC3);
    spi_byte(8'h11, r); spi_byte(8'h22, r); spi_byte(8'hC3, r); spi_byte(8'h00, r);
    cs_end(); settle();
    check(wr_total - wbase == 3, "R4 write count", wr_total - wbase, 3);
    check(exp_wr.size() == 0, "R4 writes drained", exp_wr.size(), 0);

    // R4 idle only: no write
    wbase = wr_total;
    cs_begin(); spi_byte(8'h08, r); spi_byte(8'hEE, r); cs_end(); settle();
    check(wr_total == wbase, "R4 idle not written", wr_total - wbase, 0);

    // R5 / R7 plain read
    base = rd_total;
    cs_begin();
    spi_byte(8'h0A, r); check(r == 0, "R10 rd opcode miso", r, 0);
    spi_byte(8'h00, r); check(r == 0, "R10 rd idle miso", r, 0);
    for (int k = 0; k < 4; k++) begin
      spi_byte(8'hFF, r);
      check(r === rd_vals[base + k], "R5 read byte", r, rd_vals[base + k]);
    end
    cs_end(); settle();
    check(rd_total - base == 5, "R7 request count", rd_total - base, 5);

    // R6 fast read with address
    base = rd_total;
    cs_begin();
    spi_byte(8'h0B, r);
    spi_byte(8'h12, r); check(r == 0, "R10 addr miso", r, 0);
    spi_byte(8'h34, r); spi_byte(8'h56, r);
    spi_byte(8'h00, r); check(r == 0, "R10 dummy miso", r, 0);
    for (int k = 0; k < 3; k++) begin
      spi_byte(8'h00, r);
      check(r === rd_vals[base + k], "R6 fast read byte", r, rd_vals[base + k]);
      check(addr_log[base + k] === 24'h123456 + 24'(k), "R6 address",
            addr_log[base + k], 24'h123456 + k);
    end
    cs_end(); settle();
    check(rd_total - base == 4, "R7 fast request count", rd_total - base, 4);

    // R8 abort mid-write drops held and partial bytes
    wbase = wr_total;
    cs_begin(); spi_byte(8'h08, r);
    exp_wr.push_back(8'h77);
    spi_byte(8'h77, r); spi_byte(8'h88, r); spi_byte(8'h99, r, 4);
    cs_end(); settle();
    check(wr_total - wbase == 1 && exp_wr.size() == 0, "R8 abort write", wr_total - wbase, 1);
    cs_begin(); spi_byte(8'h09, r); spi_byte(8'h3C, r); cs_end(); exp_cfg = 8'h3C; settle();
    check(cfg_pins === 8'h3C, "R8 opcode after abort", cfg_pins, 8'h3C);

    // R8 abort within opcode
    cs_begin(); spi_byte(8'h0C, r, 3); cs_end(); settle();
    cs_begin(); spi_byte(8'h09, r); spi_byte(8'hC3, r); cs_end(); exp_cfg = 8'hC3; settle();
    check(cfg_pins === 8'hC3 && led5_n === 1'b1, "R8 partial opcode", cfg_pins, 8'hC3);

    // R9 unknown opcode ignores the rest
    base = rd_total; wbase = wr_total;
    cs_begin();
    spi_byte(8'h55, r); spi_byte(8'h09, r); spi_byte(8'h00, r); spi_byte(8'h0C, r);
    spi_byte(8'h0A, r); spi_byte(8'h00, r);
    cs_end(); settle();
    check(cfg_pins === 8'hC3 && led5_n === 1'b1, "R9 unknown ignored", {cfg_pins, led5_n}, {8'hC3, 1'b1});
    check(rd_total == base && wr_total == wbase, "R9 no strobes", rd_total - base, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule